// File: doc/BRIEF.md
# Recovered-Clock Loss-of-Lock Monitor

This block checks whether a recovered receive clock runs at the same frequency as a local reference clock. Over a fixed window, or gate, of reference cycles it counts edges of the recovered clock. It then decides whether that count falls inside a ±ppm pass band around the nominal value. Each decision is reported with a one-cycle strobe and a pass/fail bit.

A loss-of-lock flag sits on top of these per-gate decisions. The flag rises only after a run of failing gates that covers the declare duration. It falls only after a run of passing gates that covers the clear duration. The two durations are set separately.

Gates that end while receive loss-of-signal is present are discarded. Toggling the re-arm input returns the detector to a clean state. Software must do this once after power-up and configuration.

Top module: `lol_monitor`

## Requirements
- R1: While `rst_n` is low, `lol`, `meas_stb` and `meas_pass` are 0. The gate counter starts from reset release. The first gate only primes the measurement and produces no strobe. The first strobe is high in the cycle after the 2·GATE_CYCLES-th rising `ref_clk` edge following release.
- R2: `meas_stb` is a single-cycle pulse. Consecutive strobes are exactly GATE_CYCLES reference cycles apart.
- R3: With TOL = ceil(GATE_CYCLES·PPM/10^6), the gate passes when its recovered-edge count lies in [GATE_CYCLES−TOL−1, GATE_CYCLES+TOL+1]. A pass is shown as `meas_pass`=1 during the strobe, and a failure as 0. With the default PPM=100, this is a ±100 ppm window plus one count of sampling guard.
- R4: Let ASSERT_GATES = max(1, ceil(ASSERT_US·REF_KHZ/(1000·GATE_CYCLES))). `lol` rises in the same cycle as the strobe of the ASSERT_GATES-th consecutive failing gate.
- R5: Let CLEAR_GATES = max(1, ceil(CLEAR_US·REF_KHZ/(1000·GATE_CYCLES))). `lol` falls in the same cycle as the strobe of the CLEAR_GATES-th consecutive passing gate.
- R6: Any gate with the opposite outcome restarts the current run. A passing gate resets the failing run, and a failing gate resets the passing run. `lol` changes only on a strobe or a re-arm.
- R7: `los` is sampled synchronously to `ref_clk`. If it is high at a gate end, that gate gives no strobe and leaves both runs and `lol` unchanged. Runs resume with the next gate that ends while `los` is low.
- R8: Any change of level on `rearm`, rising or falling, is seen on the next `ref_clk` edge. That edge forces `lol` low and clears both runs. It also restarts the gate with a new priming gate, so the next strobe follows 2·GATE_CYCLES edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; all outputs are synchronous to it |
| rec_clk | input | 1 | Recovered receive clock being monitored |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rearm | input | 1 | Re-arm control; each toggle re-initializes the detector |
| los | input | 1 | Receive loss-of-signal status, synchronous to ref_clk |
| lol | output | 1 | Loss-of-lock flag |
| meas_stb | output | 1 | One-cycle pulse at the end of each evaluated gate |
| meas_pass | output | 1 | Gate verdict, valid with meas_stb (1 = within band) |

## Verification
A wrong run count shows up at the ports within one gate of the fault. `lol` then moves on a strobe one or more gates earlier or later than the number of consecutive verdicts allows. A wrong snapshot or a broken clock crossing bends the edge count and flips `meas_pass` on the very next strobe. The recovered periods used for this sit clearly inside or outside the band. A re-arm or LOS path that leaks shows up in two ways: as `lol` still high one cycle after a toggle, or as a strobe appearing inside a LOS window.

// File: rtl/lol_monitor.sv
module lol_monitor #(
  parameter int GATE_CYCLES = 65536,
  parameter int PPM         = 100,
  parameter int REF_KHZ     = 155520,
  parameter int ASSERT_US   = 420,
  parameter int CLEAR_US    = 500
) (
  input  logic ref_clk,
  input  logic rec_clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic los,
  output logic lol,
  output logic meas_stb,
  output logic meas_pass
);
  localparam int    GW        = $clog2(GATE_CYCLES);
  localparam int    CW        = GW + 3;
  localparam longint TOL      = (longint'(GATE_CYCLES) * PPM + 999999) / 1000000;
  localparam int    LO        = GATE_CYCLES - int'(TOL) - 1;
  localparam int    HI        = GATE_CYCLES + int'(TOL) + 1;
  localparam longint GDEN     = 1000 * longint'(GATE_CYCLES);
  localparam longint A_RAW    = (longint'(ASSERT_US) * REF_KHZ + GDEN - 1) / GDEN;
  localparam longint C_RAW    = (longint'(CLEAR_US) * REF_KHZ + GDEN - 1) / GDEN;
  localparam int    ASSERT_GATES = (A_RAW < 1) ? 1 : int'(A_RAW);
  localparam int    CLEAR_GATES  = (C_RAW < 1) ? 1 : int'(C_RAW);
  localparam int    TMAX      = (ASSERT_GATES > CLEAR_GATES) ? ASSERT_GATES : CLEAR_GATES;
  localparam int    TW        = $clog2(TMAX + 1);
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);

  // recovered-clock domain: reset release sync and Gray edge counter
  logic [1:0]    rec_rst_q;
  logic          rec_rst_n;
  logic [CW-1:0] rec_bin, rec_gray, rec_next;

  always_ff @(posedge rec_clk or negedge rst_n)
    if (!rst_n) rec_rst_q <= '0;
    else        rec_rst_q <= {rec_rst_q[0], 1'b1};

  assign rec_rst_n = rec_rst_q[1];
  assign rec_next  = rec_bin + 1'b1;

  always_ff @(posedge rec_clk or negedge rec_rst_n)
    if (!rec_rst_n) begin
      rec_bin  <= '0;
      rec_gray <= '0;
    end else begin
      rec_bin  <= rec_next;
      rec_gray <= rec_next ^ (rec_next >> 1);
    end

  // reference domain
  logic [CW-1:0] gray_s1, gray_s2, cur_bin, snap, delta;
  logic [GW-1:0] gate_cnt;
  logic [TW-1:0] bad_run, good_run;
  logic          primed, rearm_q, rearm_evt, gate_end, eval, in_band;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      gray_s1 <= '0;
      gray_s2 <= '0;
    end else begin
      gray_s1 <= rec_gray;
      gray_s2 <= gray_s1;
    end

  for (genvar i = 0; i < CW; i++) begin : g_g2b
    assign cur_bin[i] = ^gray_s2[CW-1:i];
  end

  assign delta     = cur_bin - snap;
  assign in_band   = (int'(delta) >= LO) && (int'(delta) <= HI);
  assign rearm_evt = rearm ^ rearm_q;
  assign gate_end  = (gate_cnt == GATE_LAST);
  assign eval      = gate_end && primed && !los;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      gate_cnt  <= '0;
      snap      <= '0;
      primed    <= 1'b0;
      rearm_q   <= 1'b0;
      bad_run   <= '0;
      good_run  <= '0;
      lol       <= 1'b0;
      meas_stb  <= 1'b0;
      meas_pass <= 1'b0;
    end else begin
      rearm_q   <= rearm;
      meas_stb  <= 1'b0;
      meas_pass <= 1'b0;
      if (rearm_evt) begin
        gate_cnt <= '0;
        primed   <= 1'b0;
        bad_run  <= '0;
        good_run <= '0;
        lol      <= 1'b0;
      end else begin
        gate_cnt <= gate_end ? '0 : gate_cnt + 1'b1;
        if (gate_end) begin
          snap   <= cur_bin;
          primed <= 1'b1;
        end
        if (eval) begin
          meas_stb  <= 1'b1;
          meas_pass <= in_band;
          if (in_band) begin
            bad_run <= '0;
            if (int'(good_run) < CLEAR_GATES) good_run <= good_run + 1'b1;
            if (int'(good_run) + 1 >= CLEAR_GATES) lol <= 1'b0;
          end else begin
            good_run <= '0;
            if (int'(bad_run) < ASSERT_GATES) bad_run <= bad_run + 1'b1;
            if (int'(bad_run) + 1 >= ASSERT_GATES) lol <= 1'b1;
          end
        end
      end
    end

  // R4
  lol_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lol) |-> (meas_stb && !meas_pass));
  // R5
  lol_fall_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(lol) |-> ((meas_stb && meas_pass) || $past(rearm_evt)));
  // R7
  no_stb_in_los_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    meas_stb |-> !$past(los));
  // R8
  rearm_clears_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    rearm_evt |=> (!lol && !meas_stb && bad_run == '0 && good_run == '0));
  // R2
  stb_single_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    meas_stb |=> !meas_stb);
  // R6
  no_overflow_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (int'(bad_run) <= ASSERT_GATES) && (int'(good_run) <= CLEAR_GATES));
endmodule

// File: tb/lol_monitor_test.sv
`timescale 1ns/1ps
module lol_monitor_test;
  localparam int G      = 256;
  localparam int PPMV   = 100;
  localparam int RKHZ   = 50000;
  localparam int AUS    = 42;
  localparam int CUS    = 50;
  localparam int TOLB   = (G * PPMV + 999999) / 1000000;
  localparam int LOB    = G - TOLB - 1;
  localparam int HIB    = G + TOLB + 1;
  localparam int AG     = (AUS * RKHZ + 1000 * G - 1) / (1000 * G);
  localparam int CG     = (CUS * RKHZ + 1000 * G - 1) / (1000 * G);

  logic ref_clk = 1'b0, rec_clk = 1'b0;
  logic rst_n = 1'b0, rearm = 1'b0, los = 1'b0;
  logic lol, meas_stb, meas_pass;
  real  rec_half = 10.0;

  int checks = 0, failures = 0;
  int m_bad = 0, m_good = 0;
  bit m_lol = 1'b0, done = 1'b0;

  lol_monitor #(.GATE_CYCLES(G), .PPM(PPMV), .REF_KHZ(RKHZ),
                .ASSERT_US(AUS), .CLEAR_US(CUS)) uut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n), .rearm(rearm),
    .los(los), .lol(lol), .meas_stb(meas_stb), .meas_pass(meas_pass));

  always #10 ref_clk = ~ref_clk;
  initial begin
    #3;
    forever #(rec_half) rec_clk = ~rec_clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_pass(input real half);
    real n;
    n = real'(G) * 10.0 / half;
    return (n >= real'(LOB) - 0.5) && (n <= real'(HIB) + 0.5);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic next_stb(output int cyc);
    cyc = 0;
    do begin
      @(negedge ref_clk);
      cyc++;
    end while (!meas_stb && cyc < 4 * G);
    check(meas_stb == 1'b1, "R2 strobe present", meas_stb, 1);
    check(meas_pass == exp_pass(rec_half), "R3 verdict", meas_pass, exp_pass(rec_half));
    if (exp_pass(rec_half)) begin
      m_bad = 0;
      if (m_good < CG) m_good++;
      if (m_good >= CG) m_lol = 1'b0;
    end else begin
      m_good = 0;
      if (m_bad < AG) m_bad++;
      if (m_bad >= AG) m_lol = 1'b1;
    end
    check(lol == m_lol, "R4 R5 R6 lol after strobe", lol, m_lol);
  endtask

  task automatic gates(input real half, input int n);
    int c;
    rec_half = half;
    for (int i = 0; i < n; i++) begin
      next_stb(c);
      check(c == G, "R2 strobe spacing", c, G);
    end
  endtask

  task automatic do_rearm();
    int c;
    rearm = ~rearm;
    m_bad = 0; m_good = 0; m_lol = 1'b0;
    @(negedge ref_clk);
    check(lol == 1'b0, "R8 lol low after toggle", lol, 0);
    next_stb(c);
    check(c + 1 == 2 * G + 1, "R8 priming after re-arm", c + 1, 2 * G + 1);
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c, stb_seen;
    bit lol_hold;
    real pick;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge ref_clk);
    check(lol == 0 && meas_stb == 0 && meas_pass == 0, "R1 reset outputs", {lol, meas_stb, meas_pass}, 0);
    rst_n = 1'b1;
    next_stb(c);
    check(c == 2 * G, "R1 first strobe timing", c, 2 * G);
    gates(10.0, 2);
    gates(10.025, 2);
    // R4 R6: almost enough failures, one pass, then full run
    gates(9.0, AG - 1);
    gates(10.0, 1);
    gates(11.25, AG);
    // R5 R6: almost enough passes, one failure, then full run
    gates(10.0, CG - 1);
    gates(10.15, 1);
    gates(10.0, CG);
    gates(9.85, 2);
    // R7: LOS window in the middle of a failing run
    gates(9.0, AG - 4);
    los = 1'b1;
    lol_hold = lol;
    stb_seen = 0;
    repeat (3 * G) begin
      @(negedge ref_clk);
      if (meas_stb) stb_seen++;
      if (lol != lol_hold) stb_seen += 100;
    end
    check(stb_seen == 0, "R7 nothing during LOS", stb_seen, 0);
    los = 1'b0;
    gates(9.0, 4);
    check(lol == 1'b1, "R7 run resumed after LOS", lol, 1);
    // R8: both toggle directions
    do_rearm();
    gates(9.0, AG);
    do_rearm();
    gates(10.0, 3);
    // random phase
    for (int k = 0; k < 40; k++) begin
      case ($urandom % 6)
        0: pick = 10.0;
        1: pick = 10.025;
        2: pick = 9.0;
        3: pick = 11.25;
        4: pick = 10.15;
        default: pick = 9.85;
      endcase
      gates(pick, 1 + int'($urandom % 10));
      if ($urandom % 12 == 0) do_rearm();
    end
    summary();
  end
endmodule